// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address made of a segment number and an offset into a physical address. Each segment is described by a base, a limit, a presence flag and a write-permission flag. The physical address is the base plus the offset, formed with an adder, so a segment may start at any physical address. Before an address is produced, the segment number is checked against a programmable highest-segment register, and the offset is checked against the segment's limit.

Descriptors that were used recently are held in a small fully associative buffer that is searched on the segment number. On a miss, the block issues a single read at the segment-table base plus the segment number. It then installs the returned descriptor and repeats the lookup. Software sets the table base and the highest legal segment through a small register-write port. Writing the table base empties the buffer. The block accepts one request at a time and returns either a physical address or a trap with a cause code.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req are 0, the table base is 0, the highest legal segment is 7 (every segment legal), and the descriptor buffer is empty.
- R2: An access that raises no trap responds with resp_trap 0, resp_cause 0 and resp_paddr equal to base plus offset, modulo 2^20.
- R3: When the segment number is greater than the highest-segment register, the response is a trap with cause 1, and no descriptor read is issued.
- R4: When the descriptor's presence bit is 0, the response is a trap with cause 2.
- R5: When the offset is not below the 14-bit limit, the response is a trap with cause 3. A limit of 8192 admits every offset.
- R6: A write to a descriptor whose writable bit is 0 traps with cause 4. A read of the same segment does not trap on this check.
- R7: When several trap conditions hold, the reported cause is the first in this order: segment bound, presence, offset limit, write protection.
- R8: On a buffer miss, mem_req is a one-cycle pulse with mem_addr equal to table base plus segment number, modulo 2^20. The mem_rdata word is taken as presence in bit 35, writable in bit 34, limit in bits 33:20 and base in bits 19:0.
- R9: On a buffer hit, no read is issued, and the response appears one cycle after the request is accepted.
- R10: The buffer holds 4 descriptors. A miss installs its descriptor in the slot named by a round-robin pointer, which then advances and wraps from 3 to 0, whatever the order of use.
- R11: A write to the table base (cfg_sel 0) empties the buffer and returns the pointer to slot 0. A descriptor read that is still in flight when this write happens is discarded and read again from the new table.
- R12: A request is accepted when req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the response cycle. A trap response carries resp_paddr 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 3 | Segment number |
| req_off | input | 13 | Offset within the segment |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the highest legal segment (low 3 bits) |
| cfg_wdata | input | 20 | Register write data |
| mem_req | output | 1 | Descriptor read pulse |
| mem_addr | output | 20 | Descriptor read address |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 36 | Descriptor word |
| resp_valid | output | 1 | Response present for one cycle |
| resp_trap | output | 1 | Access refused |
| resp_cause | output | 3 | 0 none, 1 bound, 2 not present, 3 limit, 4 write protect |
| resp_paddr | output | 20 | Physical address, 0 on a trap |

## Verification
The hardest case to reach from the ports is a table-base write that arrives while a descriptor read is outstanding. The stale word must then be dropped and fetched again from the new table. The bench watches for the mem_req pulse, drives the base write at the next falling edge, and expects two reads and a result taken from the new table. Round-robin replacement is observed through the count of reads. A reference model of the four slots predicts a hit or a miss for every request, and an access sequence is chosen so that round-robin evicts a segment that a least-recently-used policy would have kept. Limit boundaries are covered by sweeping, for every segment, the offsets just below, at and beyond that segment's computed limit.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEG_W  = 3;
    localparam int OFF_W  = 13;
    localparam int PA_W   = 20;
    localparam int LIM_W  = OFF_W + 1;
    localparam int DESC_W = PA_W + LIM_W + 2;
    localparam int NSEG   = 1 << SEG_W;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [PA_W-1:0]  pa_t;
    typedef logic [LIM_W-1:0] lim_t;

    // packed MSB first: present, writable, limit, base
    typedef struct packed {
        logic present;
        logic writable;
        lim_t limit;
        pa_t  base;
    } desc_t;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_BOUND   = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_LIMIT   = 3'd3,
        CAUSE_PROT    = 3'd4
    } cause_e;

    typedef struct packed {
        logic   trap;
        cause_e cause;
        pa_t    paddr;
    } xres_t;

    function automatic xres_t bound_trap();
        xres_t r;
        r.trap  = 1'b1;
        r.cause = CAUSE_BOUND;
        r.paddr = '0;
        return r;
    endfunction

    // Checks below the segment bound, in priority order
    function automatic xres_t judge(desc_t d, off_t off, logic wr);
        xres_t r;
        r.trap  = 1'b1;
        r.paddr = '0;
        if (!d.present) begin
            r.cause = CAUSE_INVALID;
        end else if ({1'b0, off} >= d.limit) begin
            r.cause = CAUSE_LIMIT;
        end else if (wr && !d.writable) begin
            r.cause = CAUSE_PROT;
        end else begin
            r.trap  = 1'b0;
            r.cause = CAUSE_NONE;
            r.paddr = d.base + pa_t'(off);
        end
        return r;
    endfunction

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
    import seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_sel,
    input  pa_t  cfg_wdata,
    output pa_t  tbase,
    output seg_t seg_max,
    output logic flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbase   <= '0;
            seg_max <= seg_t'(NSEG - 1);
        end else if (cfg_we) begin
            if (cfg_sel) seg_max <= cfg_wdata[SEG_W-1:0];
            else         tbase   <= cfg_wdata;
        end
    end

    assign flush = cfg_we && !cfg_sel;

endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  seg_t  look_seg,
    output logic  hit,
    output desc_t hit_desc,
    input  logic  fill,
    input  seg_t  fill_seg,
    input  desc_t fill_desc
);

    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [PTR_W-1:0] ptr;
    logic [N_ENT-1:0] match;
    desc_t            ent_desc [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic  v;
        seg_t  tag;
        desc_t d;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v <= 1'b0;
            end else if (fill && ptr == PTR_W'(i)) begin
                v   <= 1'b1;
                tag <= fill_seg;
                d   <= fill_desc;
            end
        end
        assign match[i]    = v && (tag == look_seg);
        assign ent_desc[i] = d;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)  ptr <= '0;
        else if (fill)     ptr <= (ptr == PTR_W'(N_ENT - 1)) ? '0 : ptr + 1'b1;
    end

    always_comb begin
        hit_desc = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) hit_desc = ent_desc[i];
        end
    end

    assign hit = |match;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [PA_W-1:0]   cfg_wdata,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic              resp_trap,
    output logic [2:0]        resp_cause,
    output logic [PA_W-1:0]   resp_paddr
);

    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FETCH} state_e;

    state_e st;
    seg_t   q_seg;
    off_t   q_off;
    logic   q_wr;
    logic   stale;
    pa_t    tbase;
    seg_t   seg_max_w;
    logic   flush;
    logic   hit;
    desc_t  hit_desc;
    logic   fill;
    xres_t  res_q;

    seg_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tbase     (tbase),
        .seg_max   (seg_max_w),
        .flush     (flush)
    );

    // A returning word is dropped if a base write came during or with it
    assign fill = (st == ST_FETCH) && mem_rvalid && !stale && !flush;

    seg_desc_cache #(.N_ENT(N_ENT)) u_cache (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .look_seg  (q_seg),
        .hit       (hit),
        .hit_desc  (hit_desc),
        .fill      (fill),
        .fill_seg  (q_seg),
        .fill_desc (desc_t'(mem_rdata))
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            resp_valid <= 1'b0;
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            stale      <= 1'b0;
            q_seg      <= '0;
            q_off      <= '0;
            q_wr       <= 1'b0;
            res_q      <= '0;
        end else begin
            resp_valid <= 1'b0;
            mem_req    <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_seg <= req_seg;
                        q_off <= req_off;
                        q_wr  <= req_write;
                        st    <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (q_seg > seg_max_w) begin
                        res_q      <= bound_trap();
                        resp_valid <= 1'b1;
                        st         <= ST_IDLE;
                    end else if (hit) begin
                        res_q      <= judge(hit_desc, q_off, q_wr);
                        resp_valid <= 1'b1;
                        st         <= ST_IDLE;
                    end else begin
                        mem_req  <= 1'b1;
                        mem_addr <= tbase + pa_t'(q_seg);
                        stale    <= flush;
                        st       <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (flush) stale <= 1'b1;
                    if (mem_rvalid) st <= ST_LOOK;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_trap  = res_q.trap;
    assign resp_cause = res_q.cause;
    assign resp_paddr = res_q.paddr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input seg_t       req_seg,
    input logic       mem_req,
    input logic       resp_valid,
    input logic       resp_trap,
    input logic [2:0] resp_cause,
    input pa_t        resp_paddr,
    input seg_t       seg_max
);

    seg_t acc_seg;

    always_ff @(posedge clk) begin
        if (req_valid && req_ready) acc_seg <= req_seg;
    end

    // R8: descriptor read is a single-cycle pulse
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R12: an accepted request makes the block busy
    a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R12: trap responses carry a zero address
    a_r12_trap_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_trap) |-> (resp_paddr == '0));

    // R2: trap flag agrees with a legal cause code
    a_r2_cause_consistent: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((resp_trap == (resp_cause != 3'd0)) && (resp_cause <= 3'd4)));

    // R3: bound cause reported exactly when the segment exceeds the register
    a_r3_bound_cause: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((acc_seg > $past(seg_max)) == (resp_cause == 3'd1)));

    // R3: no descriptor read for an out-of-bound segment
    a_r3_no_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (acc_seg <= $past(seg_max)));

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_seg    (req_seg),
    .mem_req    (mem_req),
    .resp_valid (resp_valid),
    .resp_trap  (resp_trap),
    .resp_cause (resp_cause),
    .resp_paddr (resp_paddr),
    .seg_max    (seg_max_w)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_seg = '0;
    logic [12:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_trap;
    logic [2:0]  resp_cause;
    logic [19:0] resp_paddr;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    logic [19:0] tb_tbase = '0;
    int          tb_smax  = 7;
    int          mtag [4];
    bit          mv   [4];
    int          mptr = 0;

    always #2 clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_write(req_write),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_trap(resp_trap),
        .resp_cause(resp_cause), .resp_paddr(resp_paddr)
    );

    // Descriptor table content, computed from the word address
    function automatic logic [35:0] tb_desc(input logic [19:0] a);
        logic [31:0] x;
        logic [35:0] w;
        x = {12'd0, a};
        w[19:0]  = 20'((x * 32'd499) + 32'h0F0A5);
        w[33:20] = 14'((x * 32'd613) % 32'd8193);
        w[35]    = (x % 7) != 3;
        w[34]    = (x % 3) != 0;
        return w;
    endfunction

    // Memory responder: answers each read two cycles later
    logic [19:0] mr_addr = '0;
    int          mr_cnt = 0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mr_cnt > 0) begin
            mr_cnt--;
            if (mr_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tb_desc(mr_addr);
            end
        end
        if (mem_req === 1'b1) begin
            mr_addr = mem_addr;
            mr_cnt  = 2;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < 4; i++) mv[i] = 0;
        mptr = 0;
    endtask

    task automatic cfg_write(input bit sel, input logic [19:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) tb_smax = int'(data[2:0]);
        else begin tb_tbase = data; model_flush(); end
    endtask

    task automatic do_req(input int seg, input int off, input bit wr,
                          input bit inject, input logic [19:0] nb, input string ftag);
        logic [35:0] d;
        int nf, lat, efetch, ncond;
        bit hit, b, inv, lo, pr;
        logic [2:0]  ecause;
        logic [19:0] epa;
        string ctag;
        nf = 0; lat = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_seg = 3'(seg); req_off = 13'(off); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", {31'd0, req_ready}, 32'd0);
        b = seg > tb_smax;
        hit = 0;
        for (int i = 0; i < 4; i++) if (mv[i] && mtag[i] == seg) hit = 1;
        while (!resp_valid && lat < 200) begin
            if (mem_req) begin
                nf++;
                chk("R8", {12'd0, mem_addr}, {12'd0, 20'(tb_tbase + 20'(seg))});
                if (inject && nf == 1) begin
                    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = nb;
                end
            end
            @(negedge clk);
            if (cfg_we) begin
                cfg_we = 1'b0;
                tb_tbase = nb;
                model_flush();
            end
            lat++;
        end
        if (!resp_valid) begin
            nvec++; nfail++;
            $display("FAIL R12: actual no response expected response");
            return;
        end
        efetch = b ? 0 : (hit ? 0 : (inject ? 2 : 1));
        chk(b ? "R3" : ftag, nf, efetch);
        if (!b && hit) chk("R9", lat, 1);
        if (!b && !hit) begin
            mtag[mptr] = seg; mv[mptr] = 1; mptr = (mptr + 1) % 4;
        end
        d   = tb_desc(20'(tb_tbase + 20'(seg)));
        inv = !d[35];
        lo  = {1'b0, 13'(off)} >= d[33:20];
        pr  = wr && !d[34];
        ncond = int'(b) + int'(inv) + int'(lo) + int'(pr);
        epa = '0;
        if (b)        ecause = 3'd1;
        else if (inv) ecause = 3'd2;
        else if (lo)  ecause = 3'd3;
        else if (pr)  ecause = 3'd4;
        else begin ecause = 3'd0; epa = d[19:0] + 20'(off); end
        if (ncond > 1)          ctag = "R7";
        else if (ecause == 3'd1) ctag = "R3";
        else if (ecause == 3'd2) ctag = "R4";
        else if (ecause == 3'd3) ctag = "R5";
        else if (ecause == 3'd4) ctag = "R6";
        else                     ctag = "R2";
        chk(ctag, {31'd0, resp_trap}, {31'd0, ecause != 3'd0});
        chk(ctag, {29'd0, resp_cause}, {29'd0, ecause});
        chk(ctag, {12'd0, resp_paddr}, {12'd0, epa});
    endtask

    task automatic sweep();
        int lim, off;
        for (int s = 0; s < 8; s++) begin
            lim = int'(tb_desc(20'(tb_tbase + 20'(s)))[33:20]);
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: off = 0;
                    1: off = (lim > 0) ? lim - 1 : 0;
                    2: off = (lim <= 8191) ? lim : 8191;
                    default: off = 8191;
                endcase
                for (int w = 0; w < 2; w++) do_req(s, off, w[0], 0, '0, "R8");
            end
        end
    endtask

    initial begin
        model_flush();
        repeat (4) @(negedge clk);
        chk("R1", {31'd0, resp_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, req_ready}, 32'd1);
        chk("R1", {31'd0, resp_valid}, 32'd0);
        chk("R1", {31'd0, mem_req}, 32'd0);

        // R1/R2..R7: reset table base and bound, full sweep
        sweep();

        // R10: round-robin eviction sequence
        cfg_write(1'b0, 20'h00400);
        do_req(0, 0, 0, 0, '0, "R10");
        do_req(1, 0, 0, 0, '0, "R10");
        do_req(2, 0, 0, 0, '0, "R10");
        do_req(3, 0, 0, 0, '0, "R10");
        do_req(0, 0, 0, 0, '0, "R10");
        do_req(4, 0, 0, 0, '0, "R10");
        do_req(0, 0, 0, 0, '0, "R10");
        do_req(1, 0, 0, 0, '0, "R10");
        do_req(2, 0, 0, 0, '0, "R10");
        do_req(4, 0, 0, 0, '0, "R10");

        // R11: base write flushes, then an in-flight read is replaced
        do_req(0, 5, 0, 0, '0, "R11");
        cfg_write(1'b0, 20'h31337);
        do_req(0, 5, 0, 0, '0, "R11");
        do_req(5, 7, 1, 1, 20'h0ABC0, "R11");
        do_req(5, 7, 1, 0, '0, "R11");

        // R3: reduced bound register
        cfg_write(1'b1, 20'd4);
        sweep();
        cfg_write(1'b1, 20'd0);
        for (int s = 0; s < 8; s++) do_req(s, 1, 0, 0, '0, "R3");

        // Address wrap of table base plus segment
        cfg_write(1'b1, 20'd7);
        cfg_write(1'b0, 20'hFFFFC);
        sweep();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL R12: watchdog expired, actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule